// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block scrambles a byte-wide STS-12 transmit stream. Each clock carries one byte. A frame-start pulse marks the first framing byte of the frame. A frame-position counter follows the bytes through the frame. A seven-stage linear feedback shift register produces eight keystream bits per clock, and the payload bytes are XORed with that keystream. The register is seeded with all ones at a fixed byte of every frame, so any receiver that knows the frame timing can rebuild the same keystream.

The first 36 bytes of every frame carry the framing and trace/growth overhead, and they go out unscrambled. Software has two control bits. The scramble enable turns the XOR off. The stream enable, when low, replaces the incoming data with all ones before the scrambler. The output is registered, so the block adds one clock of latency.

Top module: `frame_scrambler`

## Requirements
- R1: While reset is asserted, `dout` is 0x00. Otherwise `dout` shows the byte presented on the previous clock, after processing.
- R2: The keystream comes from the polynomial 1 + x^6 + x^7. The register is loaded with all ones at frame byte offset 36. The first keystream bit of each byte drives the MSB. So with zero data, scrambling on and the stream enabled, offsets 36 and 37 come out as 0xFE and 0x04.
- R3: Frame offsets 0–35 leave the block unchanged, and the keystream does not advance during them. Offset 0 is the byte that carries `frame_start`. Offsets 0–11 are the first framing pattern, 12–23 the second, and 24–35 the trace/growth bytes.
- R4: From offset 36 to the last byte of the frame, each byte is XORed with the next eight keystream bits, and the register steps eight times per byte.
- R5: With `scr_en` low, data passes unchanged. The register still steps at every payload byte, so scrambling that is turned back on mid-frame stays aligned to the frame.
- R6: With `strm_en` low, `din` is ignored and the byte fed to the scrambler is 0xFF. The output is therefore 0xFF in the overhead and 0xFF XOR keystream in the payload.
- R7: The frame position wraps to offset 0 after FRAME_BYTES bytes (default 9720) with no new pulse. A `frame_start` that arrives mid-frame restarts the position at offset 0.
- R8: After reset and before the first `frame_start`, no byte is scrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse on frame byte offset 0 |
| din | input | 8 | Transmit byte |
| scr_en | input | 1 | Scrambling enable |
| strm_en | input | 1 | Stream enable; low forces 0xFF data |
| dout | output | 8 | Processed byte, one clock later |

## Verification
The reseed byte is checked against literal values 0xFE then 0x04. A keystream that is off by one bit, has the wrong tap, or sends the LSB first fails this check. Turning scrambling off and back on mid-frame catches a register that freezes while disabled, because the later bytes would then be misaligned. Two more frames test frame position: one wraps without a pulse and one receives a pulse mid-frame. A counter off by one at the wrap, or one that ignores an early pulse, reseeds on the wrong byte. The bench also checks the stream-disable override inside the payload, where forcing the ones after the XOR instead of before it gives 0xFF rather than the inverted keystream. It checks the unsynchronised bytes after reset as well.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int LFSR_W  = 7;   // degree of 1 + x^6 + x^7
  localparam int TAP_POS = 6;   // middle term of the polynomial
  localparam int BYTE_W  = 8;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam lfsr_t LFSR_SEED = '1;
endpackage

// File: rtl/scr_frame_pos.sv
module scr_frame_pos #(
  parameter int FRAME_BYTES = 9720,
  parameter int POS_W       = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic [POS_W-1:0] cur_pos,
  output logic             synced
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             sync_q, sync_d;

  // offset of the byte on the bus this cycle
  always_comb begin
    cur_pos = frame_start ? '0 : pos_q;
    synced  = sync_q | frame_start;
    pos_d   = (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
    sync_d  = synced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/scr_keystream.sv
module scr_keystream
  import scr_pkg::*;
#(
  parameter int STEPS = BYTE_W
) (
  input  lfsr_t            state_in,
  output logic [STEPS-1:0] ks,
  output lfsr_t            state_out
);
  lfsr_t chain [STEPS+1];

  assign chain[0] = state_in;

  // one shift per output bit; earliest bit goes to the MSB
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign ks[STEPS-1-i] = chain[i][LFSR_W-1];
    assign chain[i+1]    = {chain[i][LFSR_W-2:0],
                            chain[i][LFSR_W-1] ^ chain[i][TAP_POS-1]};
  end

  assign state_out = chain[STEPS];
endmodule

// File: rtl/scr_lfsr_ctl.sv
module scr_lfsr_ctl
  import scr_pkg::*;
#(
  parameter int UNSCR_BYTES = 36,
  parameter int POS_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             synced,
  input  logic [POS_W-1:0] cur_pos,
  output logic             in_payload,
  output byte_t            ks
);
  localparam logic [POS_W-1:0] RESEED_POS = POS_W'(UNSCR_BYTES);

  lfsr_t state_q, state_d, src_state, stepped;
  logic  reseed, adv_en;

  always_comb begin
    in_payload = synced && (cur_pos >= RESEED_POS);
    reseed     = synced && (cur_pos == RESEED_POS);
    src_state  = reseed ? LFSR_SEED : state_q;
    adv_en     = in_payload;
    state_d    = stepped;
  end

  scr_keystream #(.STEPS(BYTE_W)) u_ks (
    .state_in (src_state),
    .ks       (ks),
    .state_out(stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFSR_SEED;
    end else if (adv_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
  import scr_pkg::*;
#(
  parameter int FRAME_BYTES = 9720,
  parameter int UNSCR_BYTES = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [7:0] din,
  input  logic       scr_en,
  input  logic       strm_en,
  output logic [7:0] dout
);
  localparam int POS_W = $clog2(FRAME_BYTES);

  logic [POS_W-1:0] cur_pos;
  logic             synced;
  logic             in_payload;
  byte_t            ks;
  byte_t            pre_data, mix_data, dout_q;

  scr_frame_pos #(.FRAME_BYTES(FRAME_BYTES), .POS_W(POS_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .cur_pos    (cur_pos),
    .synced     (synced)
  );

  scr_lfsr_ctl #(.UNSCR_BYTES(UNSCR_BYTES), .POS_W(POS_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .synced    (synced),
    .cur_pos   (cur_pos),
    .in_payload(in_payload),
    .ks        (ks)
  );

  always_comb begin
    pre_data = strm_en ? din : '1;
    mix_data = (scr_en && in_payload) ? (pre_data ^ ks) : pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else begin
      dout_q <= mix_data;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/frame_scrambler_chk.sv
module frame_scrambler_chk #(
  parameter int FRAME_BYTES = 9720,
  parameter int UNSCR_BYTES = 36,
  parameter int POS_W       = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic [7:0]       din,
  input logic             scr_en,
  input logic             strm_en,
  input logic [7:0]       dout,
  input logic [POS_W-1:0] cur_pos,
  input logic             synced
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout == 8'h00)); // R1

  AST_KEY_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && cur_pos == POS_W'(UNSCR_BYTES) && scr_en && strm_en && din == 8'h00)
      |=> (dout == 8'hFE)); // R2

  AST_OVERHEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && strm_en) |=> (dout == $past(din))); // R3

  AST_SCR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!scr_en && strm_en) |=> (dout == $past(din))); // R5

  AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!strm_en && (frame_start || !scr_en)) |=> (dout == 8'hFF)); // R6

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pos == POS_W'(FRAME_BYTES - 1)) |=> (cur_pos == '0)); // R7

  AST_UNSYNCED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && strm_en) |=> (dout == $past(din))); // R8
endmodule

bind frame_scrambler frame_scrambler_chk #(
  .FRAME_BYTES(FRAME_BYTES),
  .UNSCR_BYTES(UNSCR_BYTES),
  .POS_W      ($clog2(FRAME_BYTES))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .din        (din),
  .scr_en     (scr_en),
  .strm_en    (strm_en),
  .dout       (dout),
  .cur_pos    (cur_pos),
  .synced     (synced)
);

// File: tb/frame_scrambler_tb.sv
module frame_scrambler_tb;
  localparam int FRAME = 9720;
  localparam int OVH   = 36;

  // {din, scr_en, strm_en}
  localparam logic [9:0] TBL [16] = '{
    {8'h00, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b1}, {8'hA5, 1'b1, 1'b1}, {8'h3C, 1'b0, 1'b1},
    {8'h5A, 1'b1, 1'b1}, {8'h81, 1'b1, 1'b0}, {8'h7E, 1'b1, 1'b1}, {8'h12, 1'b0, 1'b0},
    {8'hF6, 1'b1, 1'b1}, {8'h28, 1'b1, 1'b1}, {8'hC3, 1'b0, 1'b1}, {8'h01, 1'b1, 1'b1},
    {8'h80, 1'b1, 1'b0}, {8'h55, 1'b1, 1'b1}, {8'hAA, 1'b1, 1'b1}, {8'h0F, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start;
  logic [7:0] din;
  logic       scr_en;
  logic       strm_en;
  logic [7:0] dout;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  int         m_pos = 0;
  bit         m_sync = 0;
  logic [6:0] m_r = 7'h7F;

  always #5 clk = ~clk;

  frame_scrambler u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .din(din),
    .scr_en(scr_en), .strm_en(strm_en), .dout(dout)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one byte at a falling edge, model it, compare at the next falling edge
  task automatic apply(input logic [7:0] d, input logic fs, input logic sc,
                       input logic st, input string tag, output logic [7:0] got);
    logic [7:0] pre, ks, exp;
    bit         pay;
    string      t;
    frame_start = fs; din = d; scr_en = sc; strm_en = st;
    if (fs) begin m_pos = 0; m_sync = 1; end
    pre = st ? d : 8'hFF;
    pay = m_sync && (m_pos >= OVH);
    if (m_sync && m_pos == OVH) m_r = 7'h7F;
    ks = 8'h00;
    if (pay) begin
      for (int b = 0; b < 8; b++) begin
        ks[7-b] = m_r[6];
        m_r = {m_r[5:0], m_r[6] ^ m_r[5]};
      end
    end
    exp = (pay && sc) ? (pre ^ ks) : pre;
    if (tag != "") t = tag;
    else if (!m_sync) t = "R8";
    else if (m_pos < OVH) t = "R3";
    else if (!st) t = "R6";
    else if (!sc) t = "R5";
    else t = "R4";
    m_pos = (m_pos == FRAME - 1) ? 0 : m_pos + 1;
    @(negedge clk);
    got = dout;
    chk(got, exp, t);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run not finished, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    rst_n = 1'b0; frame_start = 1'b0; din = 8'h5A; scr_en = 1'b1; strm_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout, 8'h00, "R1 reset");
    rst_n = 1'b1;

    // R8: no frame reference yet
    for (int i = 0; i < 40; i++) apply(8'(i * 7), 1'b0, 1'b1, 1'b1, "R8", g);

    // table walk over one full frame, mixed controls
    for (int i = 0; i < FRAME; i++) begin
      logic [9:0] v;
      v = TBL[i % 16];
      apply(v[9:2], (i == 0), v[1], v[0], "", g);
    end

    // R7 wrap: next frame with no pulse, zero data, R2 literal keystream
    for (int i = 0; i < OVH; i++) apply(8'h00, 1'b0, 1'b1, 1'b1, "R7 wrap ovh", g);
    apply(8'h00, 1'b0, 1'b1, 1'b1, "R7", g);
    chk(g, 8'hFE, "R2 R7 reseed byte after wrap");
    apply(8'h00, 1'b0, 1'b1, 1'b1, "R2", g);
    chk(g, 8'h04, "R2 second keystream byte");

    // R5: scrambling off for a stretch, then back on
    for (int i = 0; i < 50; i++) apply(8'hC7, 1'b0, 1'b0, 1'b1, "R5", g);
    for (int i = 0; i < 50; i++) apply(8'hC7, 1'b0, 1'b1, 1'b1, "R5 realigned", g);

    // R7: early pulse mid-frame restarts offset
    apply(8'hF6, 1'b1, 1'b1, 1'b1, "R3", g);
    chk(g, 8'hF6, "R3 framing byte untouched");
    for (int i = 1; i < OVH; i++) apply(8'h28, 1'b0, 1'b1, 1'b1, "R3", g);
    apply(8'hAA, 1'b0, 1'b1, 1'b0, "R6", g);
    chk(g, 8'h01, "R6 R7 disabled stream at reseed");
    apply(8'h33, 1'b0, 1'b1, 1'b0, "R6", g);
    chk(g, 8'hFB, "R6 disabled stream second byte");
    for (int i = 0; i < 30; i++) apply(8'(i), 1'b0, 1'b1, 1'b0, "R6", g);
    for (int i = 0; i < 30; i++) apply(8'(i * 3), 1'b0, 1'b1, 1'b1, "R4", g);

    done = 1;
    summary();
    $finish;
  end
endmodule